// File: doc/BRIEF.md
# Charge Status and Interrupt Line Driver

This block owns a single open-drain status line that serves two purposes at once. While the charger is actively charging, the line is held low as a steady level. Separately, a set of event sources (supply attach, power-good change, validation failure, over-voltage, thermal regulation, thermal shutdown and missing battery) can each raise a fixed-width low pulse on the same line to wake a host. When the line is already low for charging, an interrupt first releases it for a fixed gap and then drives the pulse, so the host always sees an edge.

Every event is also recorded in a sticky per-source status bit and in a summary interrupt bit. A per-source mask bit suppresses only the pulse: the recorded status is unaffected. A host read strobe clears the recorded bits. Pulse and gap widths are counted in ticks of an external timebase strobe (nominally 125 kHz, so 16 ticks give 128 µs).

Top module: `stat_irq_pin`

## Requirements
- R1: With no interrupt sequence in progress and `chg_active_i` high, `pull_low_o` is 1.
- R2: With no interrupt sequence in progress and `chg_active_i` low, `pull_low_o` is 0.
- R3: An unmasked event while idle and not charging drives `pull_low_o` to 1 from the next cycle for exactly PULSE_TICKS timebase ticks, after which the line returns to the charging level.
- R4: An unmasked event while idle and charging releases `pull_low_o` from the next cycle for exactly GAP_TICKS ticks, then drives it low for PULSE_TICKS ticks, then returns to the charging level.
- R5: An event whose mask bit is 1 starts no gap and no pulse.
- R6: An event on source i sets `status_o[i]` on the next cycle whatever its mask, and the bit stays set until a read strobe.
- R7: Any event sets `irq_o` on the next cycle whatever its mask, and it stays set until a read strobe.
- R8: A read strobe clears `status_o` and `irq_o` on the next cycle, except that a source firing in the same cycle as the strobe leaves its bit and `irq_o` set.
- R9: Events arriving during a gap or pulse are recorded but neither restart nor extend the sequence.
- R10: Source bit positions are: 0 supply attach, 1 power-good change, 2 validation failure, 3 over-voltage, 4 thermal regulation, 5 thermal shutdown, 6 no battery.
- R11: After reset `pull_low_o` follows the charging level only, and `status_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_active_i | input | 1 | Charging in progress |
| evt_i | input | NSRC | One-cycle event strobes, one per source |
| mask_i | input | NSRC | Per-source pulse mask, 1 suppresses the pulse |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| rd_clr_i | input | 1 | Host read strobe clearing recorded bits |
| pull_low_o | output | 1 | Enable for the open-drain pull-down |
| status_o | output | NSRC | Sticky per-source status bits |
| irq_o | output | 1 | Sticky summary interrupt bit |

## Verification
The bench builds the block with its defaults: seven sources and 16-tick gap and pulse widths, with the timebase strobe every third clock so that events land on every phase of the tick. That keeps a whole gap-plus-pulse sequence under a hundred cycles, so events in the middle of a pulse, masked events while charging, and a read strobe that coincides with a new event are all reached within a short run. Pulse and gap widths are measured by counting ticks seen while the line is low or released.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_GAP   = 2'd1,
        SEQ_PULSE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic idle;
        logic gap;
        logic pulse;
    } seq_view_t;

    localparam int SRC_SUPPLY_ATTACH = 0;
    localparam int SRC_PGOOD_CHANGE  = 1;
    localparam int SRC_VALID_FAIL    = 2;
    localparam int SRC_OVERVOLT      = 3;
    localparam int SRC_THERM_REG     = 4;
    localparam int SRC_THERM_SHDN    = 5;
    localparam int SRC_NO_BATT       = 6;

    function automatic int unsigned wider_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic line_level(input seq_view_t v, input logic chg);
        return v.pulse | (v.idle & chg);
    endfunction

endpackage

// File: rtl/stat_evt_recorder.sv
module stat_evt_recorder #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic            rd_clr_i,
    output logic [NSRC-1:0] status_o,
    output logic            irq_o,
    output logic            trig_o
);
    logic [NSRC-1:0] status_q;
    logic            irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= (status_q & {NSRC{~rd_clr_i}}) | evt_i;
            irq_q    <= (irq_q & ~rd_clr_i) | (|evt_i);
        end
    end

    assign status_o = status_q;
    assign irq_o    = irq_q;
    assign trig_o   = |(evt_i & ~mask_i);

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_summary_R7: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> irq_q);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !(|evt_i)) |=> (!irq_q && status_q == '0));

endmodule

// File: rtl/stat_pulse_seq.sv
module stat_pulse_seq
    import stat_irq_pkg::*;
#(
    parameter int GAP_TICKS   = 16,
    parameter int PULSE_TICKS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      trig_i,
    input  logic      chg_i,
    input  logic      tick_i,
    output seq_view_t view_o
);
    localparam int unsigned SPAN = wider_of(GAP_TICKS, PULSE_TICKS);
    localparam int CW = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [CW-1:0] GAP_LIM   = CW'(GAP_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LIM = CW'(PULSE_TICKS - 1);

    seq_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] lim;

    assign lim = (st_q == SEQ_GAP) ? GAP_LIM : PULSE_LIM;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            SEQ_IDLE: begin
                if (trig_i) begin
                    st_n  = chg_i ? SEQ_GAP : SEQ_PULSE;
                    cnt_n = '0;
                end
            end
            SEQ_GAP, SEQ_PULSE: begin
                if (tick_i) begin
                    if (cnt_q == lim) begin
                        st_n  = (st_q == SEQ_GAP) ? SEQ_PULSE : SEQ_IDLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + CW'(1);
                    end
                end
            end
            default: begin
                st_n  = SEQ_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign view_o.idle  = (st_q == SEQ_IDLE);
    assign view_o.gap   = (st_q == SEQ_GAP);
    assign view_o.pulse = (st_q == SEQ_PULSE);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q != SEQ_IDLE) |-> (cnt_q <= lim));

    assert_gap_after_charge_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_GAP && $past(st_q) == SEQ_IDLE) |-> $past(chg_i));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_PULSE && $past(st_q) == SEQ_PULSE) |->
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)));

    assert_one_state_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({view_o.idle, view_o.gap, view_o.pulse}) && (view_o != '0));

endmodule

// File: rtl/stat_line_drive.sv
module stat_line_drive
    import stat_irq_pkg::*;
(
    input  seq_view_t view_i,
    input  logic      chg_i,
    output logic      pull_low_o
);
    assign pull_low_o = line_level(view_i, chg_i);
endmodule

// File: rtl/stat_irq_pin.sv
module stat_irq_pin
    import stat_irq_pkg::*;
#(
    parameter int NSRC        = 7,
    parameter int GAP_TICKS   = 16,
    parameter int PULSE_TICKS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chg_active_i,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic            tick_i,
    input  logic            rd_clr_i,
    output logic            pull_low_o,
    output logic [NSRC-1:0] status_o,
    output logic            irq_o
);
    logic      trig;
    seq_view_t view;

    stat_evt_recorder #(.NSRC(NSRC)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_i),
        .mask_i   (mask_i),
        .rd_clr_i (rd_clr_i),
        .status_o (status_o),
        .irq_o    (irq_o),
        .trig_o   (trig)
    );

    stat_pulse_seq #(.GAP_TICKS(GAP_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig),
        .chg_i  (chg_active_i),
        .tick_i (tick_i),
        .view_o (view)
    );

    stat_line_drive u_drv (
        .view_i     (view),
        .chg_i      (chg_active_i),
        .pull_low_o (pull_low_o)
    );

    assert_idle_level_R1: assert property (@(posedge clk) disable iff (rst)
        view.idle |-> (pull_low_o == chg_active_i));

    assert_gap_released_R4: assert property (@(posedge clk) disable iff (rst)
        view.gap |-> !pull_low_o);

    assert_pulse_low_R3: assert property (@(posedge clk) disable iff (rst)
        view.pulse |-> pull_low_o);

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (view.idle && !(|(evt_i & ~mask_i))) |=> view.idle);

endmodule

// File: tb/stat_irq_pin_tb.sv
module stat_irq_pin_tb;
    localparam int NSRC  = 7;
    localparam int GAP   = 16;
    localparam int PULSE = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            chg = 1'b0;
    logic [NSRC-1:0] evt = '0;
    logic [NSRC-1:0] mask = '0;
    logic            tick = 1'b0;
    logic            rd = 1'b0;
    logic            pull_low;
    logic [NSRC-1:0] status;
    logic            irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit started  = 0;

    always #2 clk = ~clk;

    stat_irq_pin #(.NSRC(NSRC), .GAP_TICKS(GAP), .PULSE_TICKS(PULSE)) u_dut (
        .clk(clk), .rst(rst), .chg_active_i(chg), .evt_i(evt), .mask_i(mask),
        .tick_i(tick), .rd_clr_i(rd), .pull_low_o(pull_low), .status_o(status), .irq_o(irq)
    );

    // timebase: one tick every third clock
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    // behavioural reference: 0 idle, 1 gap, 2 pulse
    int              m_st = 0;
    int              m_cnt = 0;
    logic [NSRC-1:0] m_stat = '0;
    bit              m_irq = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_stat = '0; m_irq = 0;
        end else begin
            if (rd) begin
                m_stat = evt;
                m_irq  = (evt != 0);
            end else begin
                m_stat = m_stat | evt;
                m_irq  = m_irq | (evt != 0);
            end
            if (m_st == 0) begin
                if ((evt & ~mask) != 0) begin
                    m_st  = chg ? 1 : 2;
                    m_cnt = 0;
                end
            end else if (tick) begin
                m_cnt++;
                if (m_st == 1 && m_cnt == GAP) begin m_st = 2; m_cnt = 0; end
                else if (m_st == 2 && m_cnt == PULSE) begin m_st = 0; m_cnt = 0; end
            end
        end
        started = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (started && !finished) begin
            bit exp_low;
            exp_low = (m_st == 2) || (m_st == 0 && chg);
            if (m_st == 0) chk(chg ? "R1 level" : "R2 level", int'(pull_low), int'(exp_low));
            else if (m_st == 1) chk("R4 gap", int'(pull_low), int'(exp_low));
            else chk("R3 pulse", int'(pull_low), int'(exp_low));
            chk("R6 status", int'(status), int'(m_stat));
            chk("R7 summary", int'(irq), int'(m_irq));
        end
    end

    // tick counters while low / released
    int low_ticks = 0;
    int rel_ticks = 0;
    always @(negedge clk) begin
        if (started && !rst) begin
            if (pull_low && tick) low_ticks++;
            if (!pull_low && tick) rel_ticks++;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic fire(input logic [NSRC-1:0] bits);
        @(posedge clk); #1 evt = bits;
        @(posedge clk); #1 evt = '0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        cyc(3);
        @(negedge clk);
        chk("R11 reset line", int'(pull_low), 0);
        chk("R11 reset status", int'(status), 0);
        chk("R11 reset summary", int'(irq), 0);
        @(posedge clk); #1 rst = 1'b0;
        cyc(4);
        @(negedge clk);
        chk("R2 idle released", int'(pull_low), 0);

        // R3: pulse while not charging
        @(posedge clk); #1 low_ticks = 0;
        fire(7'b0000010);
        @(negedge clk);
        chk("R3 pulse started", int'(pull_low), 1);
        cyc(70);
        chk("R3 pulse width", low_ticks, PULSE);
        @(negedge clk);
        chk("R3 line released after pulse", int'(pull_low), 0);

        // R1: charging level
        @(posedge clk); #1 chg = 1'b1;
        @(negedge clk);
        chk("R1 charging low", int'(pull_low), 1);

        // R4: gap then pulse while charging
        @(posedge clk); #1 rel_ticks = 0;
        fire(7'b0001000);
        @(negedge clk);
        chk("R4 gap started", int'(pull_low), 0);
        cyc(120);
        chk("R4 gap width", rel_ticks, GAP);
        @(negedge clk);
        chk("R4 back to charging level", int'(pull_low), 1);

        // R5: masked event makes no gap
        @(posedge clk); #1 mask = '1; rd = 1'b1;
        @(posedge clk); #1 rd = 1'b0; rel_ticks = 0;
        fire(7'b0100000);
        cyc(80);
        chk("R5 masked no gap", rel_ticks, 0);
        @(negedge clk);
        chk("R5 masked status kept R6", int'(status), 32'h20);
        chk("R5 masked summary kept R7", int'(irq), 1);

        // R10: over-voltage lands on bit 3
        @(posedge clk); #1 rd = 1'b1;
        @(posedge clk); #1 rd = 1'b0;
        fire(7'b0001000);
        @(negedge clk);
        chk("R10 over-voltage bit", int'(status), 32'h08);

        // R8: read clears, coincident event survives
        fire(7'b0000001);
        @(posedge clk); #1 rd = 1'b1; evt = 7'b0000100;
        @(posedge clk); #1 rd = 1'b0; evt = '0;
        @(negedge clk);
        chk("R8 coincident event kept", int'(status), 32'h04);
        chk("R8 coincident summary kept", int'(irq), 1);
        @(posedge clk); #1 rd = 1'b1;
        @(posedge clk); #1 rd = 1'b0;
        @(negedge clk);
        chk("R8 cleared status", int'(status), 0);
        chk("R8 cleared summary", int'(irq), 0);

        // R9: event mid-pulse neither restarts nor extends
        @(posedge clk); #1 mask = '0; chg = 1'b0;
        @(posedge clk); #1 low_ticks = 0;
        fire(7'b1000000);
        cyc(20);
        fire(7'b0010000);
        cyc(100);
        chk("R9 pulse width unchanged", low_ticks, PULSE);
        @(negedge clk);
        chk("R9 mid-pulse event recorded", int'(status), 32'h50);

        cyc(5);
        summary();
    end
endmodule